// File: doc/BRIEF.md
# Short-Transaction SPI Command Engine

This block is a register-mapped SPI master. It runs one complete serial-flash command for each start request. The host first loads the opcode, up to three address bytes and one trailing data byte into an eight-byte register window. It then writes a control byte at offset 0. That byte chooses the serial clock rate, the number of bytes to read back (0 to 3) and a 2-bit write-length code. The write-length code allows 1, 2, 4 or 5 outgoing bytes, and the opcode counts as one of them.

The engine behaves as follows during a command:
- It holds chip select low for the whole command.
- It shifts the outgoing bytes MSB first in SPI mode 0.
- It then clocks in the requested reply bytes and places them in three read-data registers.
- A busy flag in bit 7 of offset 0 is set for the whole command. The host polls this flag before starting a command and before collecting reply data.

The three address bytes are held in the window in the reverse of wire order. The highest address byte sits at offset 4 and is sent first.

Both serial clock rates come from dividing the system clock. A parameter sets the half-period for each rate. With a 66 MHz system clock, the default half-periods of 1 and 2 cycles give about 33 MHz and 16.5 MHz.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCK is low and offset 0 reads 0x00. While a command runs, bit 7 of offset 0 reads 1. It reads 0 when the engine is idle.
- R2: A write to offset 0 starts a command only if its upper nibble is 0x4 (slow clock) or 0x5 (fast clock). Any other value leaves chip select high and busy low.
- R3: Control bits 1:0 select the outgoing byte count: code 0 sends 1 byte, code 1 sends 2, code 2 sends 4 and code 3 sends 5. The number of SCK rising edges per command is 8 times the sum of the write count and the read count.
- R4: The opcode at offset 1 is always sent first. With code 1, the second byte comes from offset 7. With codes 2 and 3, the next bytes come from offsets 4, 3 and 2 in that order. With code 3, offset 7 is sent last.
- R5: Control bits 3:2 give the reply byte count (0 to 3). Reply bytes are clocked in after the last outgoing bit. The first reply byte is readable at offset 5, the second at 6 and the third at 7.
- R6: Read-data offsets change only when a command with a read phase completes. Offsets beyond that command's read count keep their earlier values.
- R7: The bus runs in SPI mode 0. SCK idles low, MOSI changes after falling edges and MISO is sampled on rising edges. MOSI is low during the read phase.
- R8: Control bit 4 set selects a SCK half-period of FAST_HALF system clocks. Bit 4 clear selects SLOW_HALF. Chip select stays low for exactly 2 × half × (total bits) system clocks.
- R9: Chip select stays low across the write phase and the read phase together. Busy is still set in the cycle in which chip select rises and clears in the next cycle.
- R10: Host writes to any offset are ignored while busy. They neither restart the command nor change any stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register window offset |
| regWrEn | input | 1 | Host write strobe, one cycle per write |
| regWrData | input | 8 | Host write data |
| regRdData | output | 8 | Register window read data (combinational) |
| spiCsN | output | 1 | Chip select, active low |
| spiSck | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data to the device |
| spiMiso | input | 1 | Serial data from the device |

## Verification
The bench runs each of the four write-length codes once and pairs them with read counts of 0, 1, 2 and 3. This shows whether byte selection, the reverse address order and the per-code bit count are decoded separately or confused with one another. Both clock rates are used, and the measured chip-select width tells a wrong divider apart from a wrong bit count. The slave model returns a distinct pattern at every bit position, so a reply taken one bit early or late, or stored at the wrong offset, shows up. Later commands with shorter reads, or none, show whether untouched read offsets are kept. Control values with bad nibbles, and writes made during a running command, show whether blocked starts and blocked stores are actually rejected.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int MAX_TX_BYTES  = 5;
  localparam int MAX_RX_BYTES  = 3;
  localparam int TX_BITS_MAX   = 8 * MAX_TX_BYTES;
  localparam int RX_BITS_MAX   = 8 * MAX_RX_BYTES;
  localparam int XFER_BITS_MAX = TX_BITS_MAX + RX_BITS_MAX;
  localparam int BIT_CNT_W     = $clog2(XFER_BITS_MAX + 1);

  localparam logic [3:0] NIB_SLOW = 4'h4;
  localparam logic [3:0] NIB_FAST = 4'h5;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;      // capture outgoing bytes, clear reply shifter
    logic shiftTx;   // advance MOSI after a falling SCK edge
    logic sampleRx;  // take MISO on a rising SCK edge in read phase
    logic commit;    // copy reply bytes to the read-data registers
  } xferStrobe_t;

  // write-length code to outgoing byte count
  function automatic logic [2:0] codeToBytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int FAST_HALF = 1,
  parameter int SLOW_HALF = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic [7:0]  ctlByte,
  output logic        busy,
  output logic        spiCsN,
  output logic        spiSck,
  output xferStrobe_t strobe
);

  localparam int HALF_MAX = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
  localparam int DIV_W    = $clog2(HALF_MAX + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_DONE} state_t;

  state_t               state;
  logic [DIV_W-1:0]     divCnt;
  logic [DIV_W-1:0]     halfLim;
  logic [BIT_CNT_W-1:0] bitIdx;
  logic [BIT_CNT_W-1:0] txBitsQ;
  logic [BIT_CNT_W-1:0] totalBitsQ;
  logic [1:0]           rdCntQ;
  logic                 sckQ;
  logic                 csNQ;
  logic                 tick;
  logic                 lastBit;
  logic [BIT_CNT_W-1:0] wrBitsNew;
  logic [BIT_CNT_W-1:0] rdBitsNew;

  assign tick    = (state == ST_XFER) && (divCnt == halfLim - 1'b1);
  assign lastBit = (bitIdx == totalBitsQ - 1'b1);

  assign wrBitsNew = BIT_CNT_W'({codeToBytes(ctlByte[1:0]), 3'b000});
  assign rdBitsNew = BIT_CNT_W'({ctlByte[3:2], 3'b000});

  always_comb begin
    strobe          = '0;
    strobe.load     = startReq;
    strobe.shiftTx  = tick && sckQ;
    strobe.sampleRx = tick && !sckQ && (bitIdx >= txBitsQ);
    strobe.commit   = (state == ST_DONE) && (rdCntQ != 2'd0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      divCnt     <= '0;
      halfLim    <= DIV_W'(SLOW_HALF);
      bitIdx     <= '0;
      txBitsQ    <= '0;
      totalBitsQ <= '0;
      rdCntQ     <= '0;
      sckQ       <= 1'b0;
      csNQ       <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            state      <= ST_XFER;
            csNQ       <= 1'b0;
            sckQ       <= 1'b0;
            divCnt     <= '0;
            bitIdx     <= '0;
            halfLim    <= ctlByte[4] ? DIV_W'(FAST_HALF) : DIV_W'(SLOW_HALF);
            txBitsQ    <= wrBitsNew;
            totalBitsQ <= wrBitsNew + rdBitsNew;
            rdCntQ     <= ctlByte[3:2];
          end
        end
        ST_XFER: begin
          if (tick) begin
            divCnt <= '0;
            sckQ   <= ~sckQ;
            if (sckQ) begin
              if (lastBit) begin
                state <= ST_DONE;
                csNQ  <= 1'b1;
              end else begin
                bitIdx <= bitIdx + 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign spiCsN = csNQ;
  assign spiSck = sckQ;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck); // R7
  AST_CS_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !spiCsN |-> busy); // R9
  AST_BUSY_AT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCsN) |-> busy); // R9
  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCsN) |=> !busy); // R9
  AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XFER) |-> (bitIdx < totalBitsQ)); // R3

endmodule

// File: rtl/spi_cmd_dp.sv
module spi_cmd_dp
  import spi_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic        busy,
  input  xferStrobe_t strobe,
  output logic        startReq,
  input  logic        spiMiso,
  output logic        spiMosi
);

  logic [7:0]             addrHi, addrMid, addrLo, opByte, tailByte;
  logic [7:0]             rxReg [MAX_RX_BYTES];
  logic [TX_BITS_MAX-1:0] txShift;
  logic [TX_BITS_MAX-1:0] txLoad;
  logic [RX_BITS_MAX-1:0] rxShift;
  logic [RX_BITS_MAX-1:0] rxAligned;
  logic [1:0]             rdCntQ;
  logic                   hostWr;
  logic [3:0]             ctlNib;

  assign hostWr   = regWrEn && !busy;
  assign ctlNib   = regWrData[7:4];
  assign startReq = hostWr && (regAddr == 3'd0) &&
                    ((ctlNib == NIB_SLOW) || (ctlNib == NIB_FAST));

  // host-side byte storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opByte   <= '0;
      addrLo   <= '0;
      addrMid  <= '0;
      addrHi   <= '0;
      tailByte <= '0;
    end else if (hostWr) begin
      case (regAddr)
        3'd1: opByte   <= regWrData;
        3'd2: addrLo   <= regWrData;
        3'd3: addrMid  <= regWrData;
        3'd4: addrHi   <= regWrData;
        3'd7: tailByte <= regWrData;
        default: ;
      endcase
    end
  end

  // wire order: opcode, then (by code) tail / addrHi..addrLo / addrHi..addrLo,tail
  always_comb begin
    txLoad = '0;
    txLoad[TX_BITS_MAX-1 -: 8] = opByte;
    case (regWrData[1:0])
      2'd1: txLoad[TX_BITS_MAX-9 -: 8]  = tailByte;
      2'd2: txLoad[TX_BITS_MAX-9 -: 24] = {addrHi, addrMid, addrLo};
      2'd3: txLoad[TX_BITS_MAX-9 -: 32] = {addrHi, addrMid, addrLo, tailByte};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobe.load) begin
      txShift <= txLoad;
    end else if (strobe.shiftTx) begin
      txShift <= {txShift[TX_BITS_MAX-2:0], 1'b0};
    end
  end

  assign spiMosi = busy && txShift[TX_BITS_MAX-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      rdCntQ  <= '0;
    end else if (strobe.load) begin
      rxShift <= '0;
      rdCntQ  <= regWrData[3:2];
    end else if (strobe.sampleRx) begin
      rxShift <= {rxShift[RX_BITS_MAX-2:0], spiMiso};
    end
  end

  // move the first received byte to the top
  always_comb begin
    rxAligned = rxShift << {2'(MAX_RX_BYTES) - rdCntQ, 3'b000};
  end

  for (genvar gi = 0; gi < MAX_RX_BYTES; gi++) begin : g_rx
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rxReg[gi] <= '0;
      end else if (strobe.commit && (2'(gi) < rdCntQ)) begin
        rxReg[gi] <= rxAligned[RX_BITS_MAX-1-8*gi -: 8];
      end
    end
  end

  always_comb begin
    case (regAddr)
      3'd0:    regRdData = {busy, 7'b0};
      3'd1:    regRdData = opByte;
      3'd2:    regRdData = addrLo;
      3'd3:    regRdData = addrMid;
      3'd4:    regRdData = addrHi;
      3'd5:    regRdData = rxReg[0];
      3'd6:    regRdData = rxReg[1];
      default: regRdData = rxReg[2];
    endcase
  end

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable({rxReg[0], rxReg[1], rxReg[2]})); // R6
  AST_TX_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable({opByte, addrLo, addrMid, addrHi, tailByte})); // R10
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> !busy); // R10
  AST_MOSI_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sampleRx |-> !spiMosi); // R7

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int FAST_HALF = 1,
  parameter int SLOW_HALF = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       spiCsN,
  output logic       spiSck,
  output logic       spiMosi,
  input  logic       spiMiso
);

  xferStrobe_t strobe;
  logic        busy;
  logic        startReq;

  spi_cmd_ctrl #(
    .FAST_HALF(FAST_HALF),
    .SLOW_HALF(SLOW_HALF)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .ctlByte  (regWrData),
    .busy     (busy),
    .spiCsN   (spiCsN),
    .spiSck   (spiSck),
    .strobe   (strobe)
  );

  spi_cmd_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .busy      (busy),
    .strobe    (strobe),
    .startReq  (startReq),
    .spiMiso   (spiMiso),
    .spiMosi   (spiMosi)
  );

endmodule

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;

  localparam int FAST_HALF = 1;
  localparam int SLOW_HALF = 2;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] regAddr;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       spiCsN, spiSck, spiMosi;
  logic       spiMiso = 1'b0;

  always #10 clk = ~clk;

  spi_cmd_engine #(.FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) u_spi_cmd_engine (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .spiCsN(spiCsN),
    .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic checkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // bus monitors and slave model
  logic [63:0] mosiCap = '0;
  int          sckRises = 0;
  int          csLowCnt = 0;
  logic        busyAtRise = 1'b0, busyAfterRise = 1'b1;
  logic        prevCs = 1'b1;
  int          relPhase = 0;
  logic [63:0] slavePat = '0;
  int          slaveBit = 0;

  always @(posedge spiSck) begin
    mosiCap = {mosiCap[62:0], spiMosi};
    sckRises++;
  end

  always @(negedge spiCsN) begin
    slaveBit = 0;
    spiMiso  = slavePat[63];
  end

  always @(negedge spiSck) begin
    if (!spiCsN) begin
      slaveBit++;
      if (slaveBit < 64) spiMiso = slavePat[63 - slaveBit];
    end
  end

  always @(negedge clk) begin
    if (spiCsN === 1'b0) csLowCnt++;
    if (relPhase == 1) begin
      busyAfterRise = regRdData[7];
      relPhase = 2;
    end
    if (prevCs === 1'b0 && spiCsN === 1'b1) begin
      busyAtRise = regRdData[7];
      relPhase = 1;
    end
    prevCs = spiCsN;
  end

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 3'd0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
    regAddr = 3'd0;
  endtask

  task automatic clearMon();
    mosiCap = '0; sckRises = 0; csLowCnt = 0; relPhase = 0;
    busyAtRise = 1'b0; busyAfterRise = 1'b1;
  endtask

  task automatic setTx(input logic [7:0] op, a2, a3, a4, t7);
    writeReg(3'd1, op); writeReg(3'd2, a2); writeReg(3'd3, a3);
    writeReg(3'd4, a4); writeReg(3'd7, t7);
  endtask

  task automatic startXfer(input logic [7:0] ctl, input logic [63:0] pat);
    clearMon();
    slavePat = pat;
    writeReg(3'd0, ctl);
    #1 checkEq("R1 busy set during command", 64'(regRdData[7]), 64'd1);
  endtask

  task automatic finishXfer(input string name, input int nTx, input logic [39:0] txb,
                            input int nRx, input int half, input logic [63:0] pat);
    int n = 0;
    logic [63:0] expStream;
    logic [7:0]  rd;
    int nBits = 8 * (nTx + nRx);
    do begin @(negedge clk); n++; end while (regRdData[7] && n < 5000);
    repeat (2) @(negedge clk);
    checkEq({"R3 sck edge count ", name}, 64'(sckRises), 64'(nBits));
    expStream = (64'(txb) >> (8 * (5 - nTx))) << (8 * nRx);
    checkEq({"R4 R7 mosi stream ", name}, mosiCap, expStream);
    checkEq({"R8 cs low cycles ", name}, 64'(csLowCnt), 64'(2 * half * nBits));
    checkEq({"R9 busy at cs release ", name}, 64'(busyAtRise), 64'd1);
    checkEq({"R9 busy clear after release ", name}, 64'(busyAfterRise), 64'd0);
    for (int j = 0; j < nRx; j++) begin
      readReg(3'(5 + j), rd);
      checkEq({"R5 reply byte ", name}, 64'(rd), (pat >> (56 - 8 * nTx - 8 * j)) & 64'hFF);
    end
  endtask

  task automatic testReset();
    logic [7:0] rd;
    readReg(3'd0, rd);
    checkEq("R1 reset csN", 64'(spiCsN), 64'd1);
    checkEq("R1 reset sck", 64'(spiSck), 64'd0);
    checkEq("R1 reset offset0", 64'(rd), 64'h00);
  endtask

  task automatic testBadControl();
    logic [7:0] rd;
    clearMon();
    writeReg(3'd0, 8'h3C);
    writeReg(3'd0, 8'h6F);
    writeReg(3'd0, 8'hC7);
    repeat (10) @(negedge clk);
    readReg(3'd0, rd);
    checkEq("R2 no chip select on bad nibble", 64'(csLowCnt), 64'd0);
    checkEq("R2 busy stays low", 64'(rd), 64'h00);
  endtask

  task automatic testIdRead();
    setTx(8'h9F, 8'h00, 8'h00, 8'h00, 8'h00);
    startXfer(8'h5C, 64'h00EF4018_00000000);
    finishXfer("code0 rd3 fast", 1, {8'h9F, 32'h0}, 3, FAST_HALF, 64'h00EF4018_00000000);
  endtask

  task automatic testFiveByte();
    logic [7:0] rd;
    setTx(8'h0B, 8'h56, 8'h34, 8'h12, 8'hA5);
    startXfer(8'h47, 64'h00000000_007E0000);
    finishXfer("code3 rd1 slow", 5, 40'h0B123456A5, 1, SLOW_HALF, 64'h00000000_007E0000);
    readReg(3'd6, rd); checkEq("R6 offset6 kept", 64'(rd), 64'h40);
    readReg(3'd7, rd); checkEq("R6 offset7 kept", 64'(rd), 64'h18);
  endtask

  task automatic testTwoByte();
    logic [7:0] rd;
    setTx(8'h01, 8'h00, 8'h00, 8'h00, 8'h02);
    startXfer(8'h59, 64'h00003CC3_00000000);
    finishXfer("code1 rd2 fast", 2, {8'h01, 8'h02, 24'h0}, 2, FAST_HALF, 64'h00003CC3_00000000);
    readReg(3'd7, rd); checkEq("R6 offset7 kept after rd2", 64'(rd), 64'h18);
  endtask

  task automatic testBusyIgnore();
    logic [7:0] rd;
    setTx(8'h20, 8'h00, 8'h10, 8'h01, 8'h00);
    startXfer(8'h42, 64'hFFFFFFFF_FFFFFFFF);
    writeReg(3'd2, 8'hEE);
    writeReg(3'd0, 8'h5F);
    finishXfer("code2 rd0 slow", 4, {8'h20, 8'h01, 8'h10, 8'h00, 8'h00}, 0, SLOW_HALF, 64'h0);
    readReg(3'd2, rd); checkEq("R10 offset2 write while busy ignored", 64'(rd), 64'h00);
    readReg(3'd1, rd); checkEq("R4 opcode readback", 64'(rd), 64'h20);
    readReg(3'd5, rd); checkEq("R6 offset5 kept with rd0", 64'(rd), 64'h3C);
    readReg(3'd6, rd); checkEq("R6 offset6 kept with rd0", 64'(rd), 64'hC3);
    clearMon();
    repeat (10) @(negedge clk);
    checkEq("R10 no second command", 64'(csLowCnt), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; regAddr = 3'd0; regWrEn = 1'b0; regWrData = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testBadControl();
    testIdRead();
    testFiveByte();
    testTwoByte();
    testBusyIgnore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule